// File: doc/BRIEF.md
# Flag-Registered Synchronous FIFO

A single-clock queue that decouples a producer from a consumer. Words enter through a valid/ready write port and leave, oldest first, through a valid/ready read port. The array is written on the clock edge and read combinationally at the read pointer, so the head word is visible on `out_data` in the same cycle that `out_valid` is high.

Two binary pointers each advance only when their own transfer happens. One equality comparator watches the next-cycle pointer values. A small controller uses that comparison and the current operation (write only, read only, both, or neither) to keep the full and empty flags in dedicated flip-flops. The flags are not taken from an extra pointer bit. `in_ready` is the inverse of the full flag and `out_valid` is the inverse of the empty flag, so both are driven straight from registers. A separate occupancy counter drives a half-full status pin.

Back-pressure rules: a word is accepted on an edge where `in_valid` and `in_ready` are both high. A word is removed on an edge where `out_valid` and `out_ready` are both high. `in_valid` while `in_ready` is low does nothing, and `out_ready` while `out_valid` is low does nothing. Neither request has to wait for the other side.

Top module: `fifo_flagreg`

## Requirements
- R1: While `rst` is high and after it falls, the FIFO is empty: `out_valid`=0, `in_ready`=1, `half_full`=0.
- R2: Words leave in the order they were accepted. `out_data` shows the oldest stored word combinationally whenever `out_valid` is 1.
- R3: A word is stored on a rising edge where `in_valid`=1 and `in_ready`=1.
- R4: A word is removed on a rising edge where `out_valid`=1 and `out_ready`=1.
- R5: A write-only transfer that brings the stored count to DEPTH drops `in_ready` right after that edge. Any write-only transfer raises `out_valid`.
- R6: A read-only transfer that removes the last word drops `out_valid` right after that edge. Any read-only transfer raises `in_ready`.
- R7: `in_valid` while full stores nothing: the stored words and their order stay as they were.
- R8: `out_ready` while empty removes nothing. The next word written is the next word read.
- R9: A write and a read on the same edge, on a FIFO that is neither empty nor full, leave `in_ready`, `out_valid` and `half_full` unchanged.
- R10: `half_full` is 1 exactly when the stored count is at least DEPTH/2.
- R11: Both pointers wrap from DEPTH-1 to 0, and order is kept across many passes through the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Not full; a word can be accepted |
| in_data | input | DW | Word to enqueue |
| out_valid | output | 1 | Not empty; `out_data` holds the head word |
| out_ready | input | 1 | Consumer takes the head word |
| out_data | output | DW | Oldest stored word |
| half_full | output | 1 | Stored count is at least DEPTH/2 |

## Verification
The assertions assume the parameter DEPTH is a power of two, so that the binary pointers wrap exactly at the array boundary. They also assume that reset is applied before the first transfer, so that the registered flags and the occupancy counter start out consistent. The stimulus holds `rst` for several cycles and changes inputs only just after a clock edge. It also drives `in_valid` while full and `out_ready` while empty on purpose, because the design must handle these requests by ignoring them.

// File: rtl/fifo_flagreg_pkg.sv
package fifo_flagreg_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_RD   = 2'b01,
    OP_WR   = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;
endpackage

// File: rtl/fifo_ptr.sv
module fifo_ptr #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] ptr_nxt
);
  // binary counter; natural wrap at 2**AW
  assign ptr_nxt = en ? ptr + AW'(1) : ptr;

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else     ptr <= ptr_nxt;
  end

  // R8: a pointer whose enable is low does not move
  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ptr == $past(ptr));
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/fifo_flags.sv
module fifo_flags
  import fifo_flagreg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  fifo_op_e op,
  input  logic     ptr_eq_nxt,
  output logic     full,
  output logic     empty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      unique case (op)
        OP_WR: begin
          empty <= 1'b0;
          if (ptr_eq_nxt) full <= 1'b1;
        end
        OP_RD: begin
          full <= 1'b0;
          if (ptr_eq_nxt) empty <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R6 / R5: the two flags never hold together
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  // R9: a combined transfer keeps both flags
  a_r9_both_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    op == OP_BOTH |=> $stable(full) && $stable(empty));
  // R7: full only clears through a read
  a_r7_full_sticks: assert property (@(posedge clk) disable iff (rst)
    full && op != OP_RD |=> full);
endmodule

// File: rtl/fifo_flagreg.sv
module fifo_flagreg
  import fifo_flagreg_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          half_full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic          full, empty;
  logic          wr_go, rd_go;
  logic [AW-1:0] wptr, wptr_nxt, rptr, rptr_nxt;
  logic [CW-1:0] count;
  fifo_op_e      op;

  assign in_ready  = !full;
  assign out_valid = !empty;
  assign wr_go     = in_valid && !full;
  assign rd_go     = out_ready && !empty;
  assign op        = fifo_op_e'({wr_go, rd_go});

  fifo_ptr #(.AW(AW)) u_wptr (
    .clk(clk), .rst(rst), .en(wr_go), .ptr(wptr), .ptr_nxt(wptr_nxt));
  fifo_ptr #(.AW(AW)) u_rptr (
    .clk(clk), .rst(rst), .en(rd_go), .ptr(rptr), .ptr_nxt(rptr_nxt));

  fifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .we(wr_go), .waddr(wptr), .wdata(in_data),
    .raddr(rptr), .rdata(out_data));

  fifo_flags u_flags (
    .clk(clk), .rst(rst), .op(op),
    .ptr_eq_nxt(wptr_nxt == rptr_nxt),
    .full(full), .empty(empty));

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else unique case (op)
      OP_WR:   count <= count + CW'(1);
      OP_RD:   count <= count - CW'(1);
      default: ;
    endcase
  end

  assign half_full = count >= CW'(DEPTH / 2);

  // R5: full flag agrees with occupancy
  a_r5_full_vs_count: assert property (@(posedge clk) disable iff (rst)
    full == (count == CW'(DEPTH)));
  // R6: empty flag agrees with occupancy
  a_r6_empty_vs_count: assert property (@(posedge clk) disable iff (rst)
    empty == (count == '0));
  // R10: a full queue is at least half full
  a_r10_full_half: assert property (@(posedge clk) disable iff (rst)
    full |-> half_full);
  // R3: occupancy never passes depth
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: tb/tb_fifo_flagreg.sv
module tb_fifo_flagreg;
  localparam int DW = 8;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, half_full;
  logic [DW-1:0] out_data;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [$];

  always #2.5 clk = ~clk;

  fifo_flagreg #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .half_full(half_full));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_status(string req);
    check({req, " in_ready"}, 32'(in_ready), 32'(model.size() < DEPTH));
    check({req, " out_valid"}, 32'(out_valid), 32'(model.size() > 0));
    check({req, " half_full R10"}, 32'(half_full), 32'(model.size() >= DEPTH / 2));
  endtask

  task automatic push(logic [DW-1:0] v, string req);
    in_valid = 1'b1; in_data = v;
    tick();
    in_valid = 1'b0;
    model.push_back(v);
    check_status(req);
  endtask

  task automatic pop(string req);
    check({req, " head"}, 32'(out_data), 32'(model[0]));
    out_ready = 1'b1;
    tick();
    out_ready = 1'b0;
    void'(model.pop_front());
    check_status(req);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) tick();
    check("R1 in_ready during reset", 32'(in_ready), 32'd1);
    rst = 1'b0;
    tick();
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 in_ready", 32'(in_ready), 32'd1);
    check("R1 half_full", 32'(half_full), 32'd0);
  endtask

  task automatic t_fill_overflow_drain();
    for (int i = 0; i < DEPTH; i++) push(DW'(8'h10 + i), "R3 R5 fill");
    check("R5 full", 32'(in_ready), 32'd0);
    check("R2 head after fill", 32'(out_data), 32'h10);
    in_valid = 1'b1; in_data = 8'hEE;
    tick();
    in_valid = 1'b0;
    check("R7 still full", 32'(in_ready), 32'd0);
    check("R7 head kept", 32'(out_data), 32'h10);
    while (model.size() > 0) pop("R2 R4 R6 drain");
    check("R6 empty after drain", 32'(out_valid), 32'd0);
  endtask

  task automatic t_underflow();
    out_ready = 1'b1;
    repeat (2) tick();
    out_ready = 1'b0;
    check("R8 stays empty", 32'(out_valid), 32'd0);
    push(8'h5A, "R8 write after idle read");
    check("R8 head", 32'(out_data), 32'h5A);
    pop("R8 read back");
    check("R8 empty again", 32'(out_valid), 32'd0);
  endtask

  task automatic t_simultaneous();
    for (int i = 0; i < 3; i++) push(DW'(8'h30 + i), "R9 prefill");
    for (int i = 0; i < 6; i++) begin
      check("R9 head", 32'(out_data), 32'(model[0]));
      in_valid = 1'b1; in_data = DW'(8'h40 + i); out_ready = 1'b1;
      tick();
      in_valid = 1'b0; out_ready = 1'b0;
      void'(model.pop_front());
      model.push_back(DW'(8'h40 + i));
      check_status("R9 both");
    end
    while (model.size() > 0) pop("R9 drain");
  endtask

  task automatic t_wrap();
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < 5; i++) push(DW'(r * 16 + i + 1), "R11 burst in");
      for (int i = 0; i < 5; i++) pop("R11 burst out");
    end
    for (int i = 0; i < DEPTH; i++) push(DW'(8'hA0 + i), "R11 refill");
    check("R11 full after wrap", 32'(in_ready), 32'd0);
    while (model.size() > 0) pop("R11 final drain");
  endtask

  initial begin
    t_reset();
    t_fill_overflow_drain();
    t_underflow();
    t_simultaneous();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule